// File: doc/BRIEF.md
# Quadrature Carrier NCO with Frequency and Phase Offsets

This block is a numerically controlled oscillator that produces a sine sample and a cosine sample of a local carrier. These samples feed a downconversion mixer. A 32-bit phase accumulator steps once for each enabled input sample. The step size is the modulo-2^32 sum of two words. One is a parallel center-frequency word. The other is an offset-frequency word that arrives one bit at a time on a serial data pin, and a framing strobe marks the end of each word. The summed word is read as two's complement, so a negative word turns the phase backward. The usable range is minus half to plus half of the enabled sample rate, with a resolution of that rate divided by 2^32.

A 10-bit phase offset is added, with wrap, to the top accumulator bits before the lookup. One offset LSB is 1/1024 of a turn, about 0.35 degrees. The lookup is a reduced quarter-wave table. Only the top bits of the phase address select an entry, and the four quadrants are mirrored and negated from a single stored quarter. A control input can force the offset term to zero while the serially loaded word stays stored. An external clear pulse, when clearing is armed, zeroes the accumulator feedback so that several oscillators can restart in phase on a common event.

Top module: `carrier_nco`

## Requirements
- R1: While rstN is low, sinOut and cosOut are 0. The accumulator and the stored offset word are 0. After reset, with sampEn low and phaseOff 0, the outputs show the lookup of phase 0.
- R2: On each clock with sampEn high, the accumulator adds the frequency word modulo 2^32. With sampEn low and no armed clear, the accumulator holds its value.
- R3: The frequency word equals centerFreq plus the stored offset word, modulo 2^32. A word of 2^32 minus s steps the phase backward by s.
- R4: offData is shifted in one bit per clock, MSB first. On a clock where offSync is high, the 32 most recent bits are stored as the offset word. The bit present in the offSync cycle becomes bit 0. The new word is used from the following clock on. Without offSync the stored word is unchanged.
- R5: While offZero is high, the offset term is 0 and only centerFreq is used. The stored offset word is kept and takes effect again as soon as offZero falls.
- R6: The lookup phase is the top 10 accumulator bits plus phaseOff, modulo 1024. A phaseOff of 256 shifts the phase by a quarter turn, and the sine then shows the value the cosine had.
- R7: On a clock with accClr and clrEn both high, the accumulator takes the frequency word if sampEn is high, and 0 otherwise. While clrEn is low, accClr has no effect.
- R8: Let k be the top 8 bits of the lookup phase. sinOut is round(131071*sin(2*pi*(k+0.5)/256)) within 2 LSB, and cosOut is the same expression at k+64. Both are signed 18-bit values. Each output is registered, so on every clock it shows the lookup of the accumulator value and phaseOff held before that edge. The magnitude never exceeds 131071.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampEn | input | 1 | Sample enable; the accumulator steps only when high |
| centerFreq | input | 32 | Active center-frequency word |
| phaseOff | input | 10 | Phase offset added to the top accumulator bits |
| offData | input | 1 | Serial offset-frequency data, MSB first |
| offSync | input | 1 | Framing strobe; stores the assembled offset word |
| offZero | input | 1 | Forces the offset term to zero |
| clrEn | input | 1 | Arms the accumulator clear |
| accClr | input | 1 | Accumulator-clear pulse |
| sinOut | output | 18 | Signed sine sample |
| cosOut | output | 18 | Signed cosine sample |

## Verification
The riskiest coincidence is an armed clear pulse landing on the same clock as an enabled sample. The accumulator must then take exactly one step from zero. It must not hold at zero, and it must not add to the old phase. A second coincidence is an offset-word capture on a clock that also advances the accumulator. That step must still use the old offset, and the next step must use the new one. The bench provokes both cases by driving the clear with sampEn high and low, and by framing a serial load with sampEn held high throughout. The outcome is judged from the sine and cosine samples on the following clocks. These are compared against a bench-side accumulator model and a real-valued sine computed from the requirement formula.

// File: rtl/carrier_nco_pkg.sv
package carrier_nco_pkg;

  typedef struct packed {
    logic advance;
    logic clearFb;
    logic useOffset;
  } ncoStrobes_t;

  // Quarter-wave sine sample at the midpoint of entry idx out of qn entries,
  // scaled to the largest positive value of an ampW-bit signed word.
  function automatic logic [31:0] sinQuarter(input int idx, input int qn, input int ampW);
    longint piQ30;
    longint x;
    longint x2;
    longint term;
    longint sum;
    longint amp;
    piQ30 = 64'sd3373259426;
    amp   = (64'sd1 <<< (ampW - 1)) - 64'sd1;
    x     = ((2 * longint'(idx) + 1) * piQ30) / (4 * longint'(qn));
    x2    = (x * x) >>> 30;
    term  = x;
    sum   = x;
    for (int n = 1; n <= 7; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    sinQuarter = 32'((sum * amp + (64'sd1 <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import carrier_nco_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampEn,
  input  logic              offData,
  input  logic              offSync,
  input  logic              offZero,
  input  logic              clrEn,
  input  logic              accClr,
  output ncoStrobes_t       strobes,
  output logic [ACC_W-1:0]  offsetWord
);

  logic [ACC_W-2:0] shiftReg;
  logic [ACC_W-1:0] assembled;

  assign assembled = {shiftReg, offData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      offsetWord <= '0;
    end else begin
      shiftReg <= assembled[ACC_W-2:0];
      if (offSync) begin
        offsetWord <= assembled;
      end
    end
  end

  always_comb begin
    strobes.advance   = sampEn;
    strobes.clearFb   = accClr & clrEn;
    strobes.useOffset = ~offZero;
  end

endmodule

// File: rtl/nco_quarter_lut.sv
module nco_quarter_lut
  import carrier_nco_pkg::*;
#(
  parameter int QBITS = 6,
  parameter int AMP_W = 18,
  localparam int IDX_W = QBITS + 2,
  localparam int QN = 1 << QBITS
) (
  input  logic [IDX_W-1:0]        idx,
  output logic signed [AMP_W-1:0] sinVal,
  output logic signed [AMP_W-1:0] cosVal
);

  logic [AMP_W-1:0] quarterTbl [QN];

  for (genvar g = 0; g < QN; g++) begin : g_tbl
    assign quarterTbl[g] = AMP_W'(sinQuarter(g, QN, AMP_W));
  end

  logic [IDX_W-1:0] cosIdx;
  assign cosIdx = idx + IDX_W'(QN);

  function automatic logic signed [AMP_W-1:0] unfold(input logic [IDX_W-1:0] p,
                                                     input logic [AMP_W-1:0] magA,
                                                     input logic [AMP_W-1:0] magB);
    logic [AMP_W-1:0] mag;
    mag = p[QBITS] ? magB : magA;
    unfold = p[IDX_W-1] ? -$signed(mag) : $signed(mag);
  endfunction

  logic [QBITS-1:0] sinI, cosI;
  assign sinI = idx[QBITS-1:0];
  assign cosI = cosIdx[QBITS-1:0];

  always_comb begin
    sinVal = unfold(idx, quarterTbl[sinI], quarterTbl[~sinI]);
    cosVal = unfold(cosIdx, quarterTbl[cosI], quarterTbl[~cosI]);
  end

endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import carrier_nco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PO_W  = 10,
  parameter int QBITS = 6,
  parameter int AMP_W = 18,
  localparam int IDX_W = QBITS + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ncoStrobes_t             strobes,
  input  logic [ACC_W-1:0]        centerFreq,
  input  logic [ACC_W-1:0]        offsetWord,
  input  logic [PO_W-1:0]         phaseOff,
  output logic [ACC_W-1:0]        accVal,
  output logic [ACC_W-1:0]        freqWord,
  output logic signed [AMP_W-1:0] sinOut,
  output logic signed [AMP_W-1:0] cosOut
);

  logic [ACC_W-1:0] accNext;
  logic [ACC_W-1:0] feedback;
  logic [PO_W-1:0]  phaseHi;
  logic [IDX_W-1:0] lutIdx;
  logic             unusedLsb;
  logic signed [AMP_W-1:0] lutSin, lutCos;

  assign freqWord = centerFreq + (strobes.useOffset ? offsetWord : '0);
  assign feedback = strobes.clearFb ? '0 : accVal;
  assign accNext  = strobes.advance ? feedback + freqWord : feedback;

  assign phaseHi   = accVal[ACC_W-1 -: PO_W] + phaseOff;
  assign lutIdx    = phaseHi[PO_W-1 -: IDX_W];
  assign unusedLsb = ^phaseHi[PO_W-IDX_W-1:0];

  nco_quarter_lut #(.QBITS(QBITS), .AMP_W(AMP_W)) lut_i (
    .idx    (lutIdx),
    .sinVal (lutSin),
    .cosVal (lutCos)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accVal <= '0;
      sinOut <= '0;
      cosOut <= '0;
    end else begin
      accVal <= accNext;
      sinOut <= lutSin;
      cosOut <= lutCos;
    end
  end

endmodule

// File: rtl/carrier_nco.sv
module carrier_nco
  import carrier_nco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PO_W  = 10,
  parameter int QBITS = 6,
  parameter int AMP_W = 18
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampEn,
  input  logic [ACC_W-1:0]        centerFreq,
  input  logic [PO_W-1:0]         phaseOff,
  input  logic                    offData,
  input  logic                    offSync,
  input  logic                    offZero,
  input  logic                    clrEn,
  input  logic                    accClr,
  output logic signed [AMP_W-1:0] sinOut,
  output logic signed [AMP_W-1:0] cosOut
);

  ncoStrobes_t      strobes;
  logic [ACC_W-1:0] offsetWord;
  logic [ACC_W-1:0] accVal;
  logic [ACC_W-1:0] freqWord;

  nco_ctrl #(.ACC_W(ACC_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampEn     (sampEn),
    .offData    (offData),
    .offSync    (offSync),
    .offZero    (offZero),
    .clrEn      (clrEn),
    .accClr     (accClr),
    .strobes    (strobes),
    .offsetWord (offsetWord)
  );

  nco_datapath #(.ACC_W(ACC_W), .PO_W(PO_W), .QBITS(QBITS), .AMP_W(AMP_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .centerFreq (centerFreq),
    .offsetWord (offsetWord),
    .phaseOff   (phaseOff),
    .accVal     (accVal),
    .freqWord   (freqWord),
    .sinOut     (sinOut),
    .cosOut     (cosOut)
  );

endmodule

// File: rtl/nco_checker.sv
module nco_checker #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 18
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    sampEn,
  input logic                    offSync,
  input logic                    offZero,
  input logic                    clrEn,
  input logic                    accClr,
  input logic [ACC_W-1:0]        centerFreq,
  input logic [ACC_W-1:0]        accVal,
  input logic [ACC_W-1:0]        freqWord,
  input logic [ACC_W-1:0]        offsetWord,
  input logic signed [AMP_W-1:0] sinOut,
  input logic signed [AMP_W-1:0] cosOut
);

  localparam logic signed [AMP_W-1:0] AMP = {1'b0, {(AMP_W-1){1'b1}}};

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sampEn && !(accClr && clrEn)) |=> $stable(accVal));

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampEn && !(accClr && clrEn)) |=> (accVal == $past(accVal) + $past(freqWord)));

  // R4
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !offSync |=> $stable(offsetWord));

  // R5
  offset_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offZero && sampEn && !(accClr && clrEn)) |=> (accVal == $past(accVal) + $past(centerFreq)));

  // R7
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accClr && clrEn && !sampEn) |=> (accVal == '0));

  // R7
  clear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accClr && clrEn && sampEn) |=> (accVal == $past(freqWord)));

  // R8
  amp_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinOut >= -AMP) && (cosOut >= -AMP));

endmodule

bind carrier_nco nco_checker #(.ACC_W(ACC_W), .AMP_W(AMP_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sampEn     (sampEn),
  .offSync    (offSync),
  .offZero    (offZero),
  .clrEn      (clrEn),
  .accClr     (accClr),
  .centerFreq (centerFreq),
  .accVal     (accVal),
  .freqWord   (freqWord),
  .offsetWord (offsetWord),
  .sinOut     (sinOut),
  .cosOut     (cosOut)
);

// File: tb/carrier_nco_tb_top.sv
module carrier_nco_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampEn = 1'b0;
  logic [31:0] centerFreq = '0;
  logic [9:0]  phaseOff = '0;
  logic        offData = 1'b0;
  logic        offSync = 1'b0;
  logic        offZero = 1'b0;
  logic        clrEn = 1'b0;
  logic        accClr = 1'b0;
  logic signed [17:0] sinOut, cosOut;

  carrier_nco dut_i (
    .clk(clk), .rstN(rstN), .sampEn(sampEn), .centerFreq(centerFreq),
    .phaseOff(phaseOff), .offData(offData), .offSync(offSync), .offZero(offZero),
    .clrEn(clrEn), .accClr(accClr), .sinOut(sinOut), .cosOut(cosOut)
  );

  always #2.5 clk = ~clk;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;
  string curTag = "R1";

  logic [31:0] mAcc = '0;
  logic [31:0] mOff = '0;
  logic [30:0] mShift = '0;
  int expSin = 0;
  int expCos = 0;

  function automatic int refSin(input int k);
    real a;
    real v;
    a = 2.0 * 3.14159265358979 * (real'(k & 255) + 0.5) / 256.0;
    v = 131071.0 * $sin(a);
    if (v >= 0.0) refSin = $rtoi(v + 0.5);
    else refSin = -$rtoi(-v + 0.5);
  endfunction

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    checkCnt++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: update the bench model at the edge, then check at the falling edge.
  task automatic tick();
    logic [31:0] freq;
    logic [9:0]  hi;
    logic [30:0] nShift;
    @(posedge clk);
    freq = centerFreq + (offZero ? 32'd0 : mOff);
    hi = mAcc[31:22] + phaseOff;
    expSin = refSin(int'(hi[9:2]));
    expCos = refSin(int'(hi[9:2]) + 64);
    if (accClr && clrEn) mAcc = sampEn ? freq : 32'd0;
    else if (sampEn) mAcc = mAcc + freq;
    nShift = {mShift[29:0], offData};
    if (offSync) mOff = {mShift, offData};
    mShift = nShift;
    @(negedge clk);
    check({curTag, " sin"}, int'(sinOut), expSin, 2);
    check({curTag, " cos"}, int'(cosOut), expCos, 2);
  endtask

  task automatic loadOffset(input logic [31:0] word);
    for (int b = 31; b >= 0; b--) begin
      offData = word[b];
      offSync = (b == 0);
      tick();
    end
    offSync = 1'b0;
    offData = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL %s watchdog actual=hung expected=done", curTag);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 sin in reset", int'(sinOut), 0, 0);
    check("R1 cos in reset", int'(cosOut), 0, 0);
    rstN = 1'b1;
    tick();
    tick();

    // R2: enabled stepping with gaps
    curTag = "R2";
    centerFreq = 32'h0123_4567;
    for (int c = 0; c < 300; c++) begin
      sampEn = (c % 3) != 0;
      tick();
    end

    // R3: negative frequency steps backward
    curTag = "R3";
    sampEn = 1'b1;
    centerFreq = 32'h0 - 32'h0300_0000;
    for (int c = 0; c < 200; c++) tick();

    // R4: serial load with enable high, sum wraps modulo 2^32
    curTag = "R4";
    centerFreq = 32'h0180_0000;
    loadOffset(32'hFF80_0000);
    for (int c = 0; c < 100; c++) tick();
    loadOffset(32'h0051_A3C7);
    for (int c = 0; c < 60; c++) tick();

    // R5: force offset to zero and release
    curTag = "R5";
    for (int c = 0; c < 150; c++) begin
      offZero = ((c / 7) % 2) == 1;
      tick();
    end
    offZero = 1'b0;

    // R6: sweep every phase offset with the accumulator frozen
    curTag = "R6";
    sampEn = 1'b0;
    for (int p = 0; p < 1024; p++) begin
      phaseOff = 10'(p);
      tick();
    end
    phaseOff = 10'd0;

    // R7: clear alone, clear with an enabled sample, clear while disarmed
    curTag = "R7";
    sampEn = 1'b1;
    tick();
    clrEn = 1'b1; accClr = 1'b1; sampEn = 1'b0;
    tick();
    accClr = 1'b0;
    tick(); tick();
    sampEn = 1'b1;
    repeat (5) tick();
    accClr = 1'b1;
    tick();
    accClr = 1'b0;
    repeat (5) tick();
    clrEn = 1'b0; accClr = 1'b1;
    repeat (4) tick();
    accClr = 1'b0;
    tick();

    // R8: walk every lookup index with a quarter-turn phase offset too
    curTag = "R8";
    offZero = 1'b1;
    centerFreq = 32'h0100_0000;
    clrEn = 1'b1; accClr = 1'b1; sampEn = 1'b0;
    tick();
    accClr = 1'b0; clrEn = 1'b0; sampEn = 1'b1;
    for (int c = 0; c < 300; c++) tick();
    phaseOff = 10'd256;
    for (int c = 0; c < 260; c++) tick();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule